// File: doc/BRIEF.md
# Common-Command Responder for an I3C Target

This block is the part of an I3C target that answers the common command codes every device on the bus shares. It works at the byte level: a bus front end hands it one event per cycle. The event is a START or repeated START with a 7-bit address and a direction, a written byte, a request for a read byte, or a STOP. The block answers each START, write and read one cycle later with an ACK/NACK flag and, for reads, the data byte.

Inside, the block keeps a dynamic address, a command-in-progress flag, the latched command code, a byte offset and a test-mode flag. The static address, 48-bit provisioned ID, bus characteristics byte and device characteristics byte are parameters. From this state the block decides which addresses to acknowledge. It steps through the dynamic-address-assignment exchange: it streams the ID and the two characteristic bytes, then takes the ninth byte as its new address. It also applies the address-setting commands and returns the ID and characteristic bytes for the read commands.

Top module: `i3c_ccc_target`

## Requirements
- R1: After reset the dynamic address is 0, test mode is off, no command is active, `rsp_valid` is low and `rsp_data` is 8'hFF.
- R2: Event kinds on `ev_kind` are 0 = START, 1 = WRITE, 2 = READ, 3 = STOP. Outside address assignment, a START is acknowledged when its address is 7'h7E (broadcast). It is also acknowledged when its address equals the dynamic address, if that is non-zero, or otherwise the static address. Every START, WRITE and READ gets exactly one response, with `rsp_valid` high in the cycle after the event.
- R3: While address assignment is active (broadcast command 8'h07 until STOP), a START is acknowledged only if its address is 7'h7E and the dynamic address is 0.
- R4: Reads during address assignment return the 6 ID bytes, least significant first, then the bus characteristics byte, then the device characteristics byte. Each of these reads advances the byte offset. Further reads return 8'hFF and leave the offset at 8.
- R5: A byte written when the offset is 8 becomes the dynamic address (its bits [6:0]). The write also clears the command and the offset. A later broadcast START in the same assignment is then NACKed.
- R6: Command 8'h06 clears the dynamic address to 0. Commands 8'h29 and 8'h87 copy the static address into the dynamic address.
- R7: After command 8'h88, the first data byte written (also through a directed repeated START) sets the dynamic address to its bits [6:0].
- R8: After command 8'h0B, the next written byte turns test mode on if non-zero and off if zero. In test mode the ID streamed during address assignment is 48'h0000554D4551. The ID read by command 8'h8D is unchanged.
- R9: Command 8'h8D returns the 6 ID bytes, least significant first, and then 8'hFF. Command 8'h8E returns the bus characteristics byte and 8'h8F returns the device characteristics byte.
- R10: STOP clears the command code, the byte offset, the in-command flag and the assignment state. A read with no active command returns 8'hFF with ACK.
- R11: An unrecognised command code changes no address or mode state, and reads under it return 8'hFF. A WRITE or READ in a frame whose START was NACKed is NACKed, with data 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_kind | input | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| ev_addr | input | 7 | Address carried by a START |
| ev_rnw | input | 1 | Direction of a START (1 = read) |
| ev_data | input | 8 | Byte carried by a WRITE |
| rsp_valid | output | 1 | Response to the previous cycle's event |
| rsp_ack | output | 1 | 1 = ACK, 0 = NACK |
| rsp_data | output | 8 | Read byte (8'hFF when none) |

## Verification
Every result of this block comes from one register stage. A START's ACK, a WRITE's acknowledgement and a READ's byte all appear exactly one clock after the cycle the event is sampled. A state change made by a write (a new dynamic address, test mode) becomes visible on the next START's ACK or the next assignment read, one cycle after that event. The driver applies each event on a falling edge and queues its expected response. The monitor takes one entry from the queue at each following falling edge where `rsp_valid` is high, so every compare lands on the single cycle in which that response is due.

// File: rtl/i3c_ccc_pkg.sv
package i3c_ccc_pkg;

   typedef enum logic [1:0] {
      EV_START = 2'd0,
      EV_WRITE = 2'd1,
      EV_READ  = 2'd2,
      EV_STOP  = 2'd3
   } ev_kind_e;

   localparam logic [6:0] BCAST_ADDR = 7'h7E;

   localparam logic [7:0] CMD_ASSIGN   = 8'h07;
   localparam logic [7:0] CMD_CLRADDR  = 8'h06;
   localparam logic [7:0] CMD_TESTMODE = 8'h0B;
   localparam logic [7:0] CMD_ALLSTAT  = 8'h29;
   localparam logic [7:0] CMD_ONESTAT  = 8'h87;
   localparam logic [7:0] CMD_NEWADDR  = 8'h88;
   localparam logic [7:0] CMD_RDID     = 8'h8D;
   localparam logic [7:0] CMD_RDBUSCH  = 8'h8E;
   localparam logic [7:0] CMD_RDDEVCH  = 8'h8F;

   localparam logic [7:0] IDLE_BYTE = 8'hFF;

endpackage

// File: rtl/i3c_ccc_addr_match.sv
module i3c_ccc_addr_match
   import i3c_ccc_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ADDR_W-1:0] static_addr,
   input  logic [ADDR_W-1:0] dyn_addr,
   input  logic              assign_active,
   output logic              is_bcast,
   output logic              hit
);

   logic              have_dyn;
   logic [ADDR_W-1:0] own_addr;

   assign is_bcast = (req_addr == ADDR_W'(BCAST_ADDR));
   assign have_dyn = |dyn_addr;
   assign own_addr = have_dyn ? dyn_addr : static_addr;

   always_comb begin
      if (assign_active) begin
         hit = is_bcast && !have_dyn;
      end else begin
         hit = is_bcast || (req_addr == own_addr);
      end
   end

endmodule

// File: rtl/i3c_ccc_rd_mux.sv
module i3c_ccc_rd_mux
   import i3c_ccc_pkg::*;
#(
   parameter int                 ID_BYTES = 6,
   parameter int                 OFF_W    = 4,
   parameter logic [8*ID_BYTES-1:0] ID_VAL   = '0,
   parameter logic [8*ID_BYTES-1:0] TEST_ID  = '0,
   parameter logic [7:0]         BUS_CHAR = 8'h00,
   parameter logic [7:0]         DEV_CHAR = 8'h00
) (
   input  logic             in_cmd,
   input  logic [7:0]       cmd,
   input  logic [OFF_W-1:0] offset,
   input  logic             test_mode,
   output logic [7:0]       rd_byte,
   output logic             advance
);

   logic [7:0] id_b   [ID_BYTES];
   logic [7:0] tst_b  [ID_BYTES];

   for (genvar b = 0; b < ID_BYTES; b++) begin : g_idbyte
      assign id_b[b]  = ID_VAL[8*b +: 8];
      assign tst_b[b] = TEST_ID[8*b +: 8];
   end

   logic [7:0] id_sel;
   logic [7:0] tst_sel;
   logic       in_id;

   always_comb begin
      id_sel  = IDLE_BYTE;
      tst_sel = IDLE_BYTE;
      in_id   = 1'b0;
      for (int b = 0; b < ID_BYTES; b++) begin
         if (offset == OFF_W'(b)) begin
            id_sel  = id_b[b];
            tst_sel = tst_b[b];
            in_id   = 1'b1;
         end
      end
   end

   always_comb begin
      rd_byte = IDLE_BYTE;
      advance = 1'b0;
      if (in_cmd) begin
         case (cmd)
            CMD_ASSIGN: begin
               if (in_id) begin
                  rd_byte = test_mode ? tst_sel : id_sel;
                  advance = 1'b1;
               end else if (offset == OFF_W'(ID_BYTES)) begin
                  rd_byte = BUS_CHAR;
                  advance = 1'b1;
               end else if (offset == OFF_W'(ID_BYTES + 1)) begin
                  rd_byte = DEV_CHAR;
                  advance = 1'b1;
               end
            end
            CMD_RDID: begin
               if (in_id) begin
                  rd_byte = id_sel;
                  advance = 1'b1;
               end
            end
            CMD_RDBUSCH: rd_byte = BUS_CHAR;
            CMD_RDDEVCH: rd_byte = DEV_CHAR;
            default: rd_byte = IDLE_BYTE;
         endcase
      end
   end

endmodule

// File: rtl/i3c_ccc_target.sv
module i3c_ccc_target
   import i3c_ccc_pkg::*;
#(
   parameter int                     ADDR_W      = 7,
   parameter int                     ID_BYTES    = 6,
   parameter logic [ADDR_W-1:0]      STATIC_ADDR = 7'h2A,
   parameter logic [8*ID_BYTES-1:0]  ID_VAL      = 48'hA1B2C3D4E5F6,
   parameter logic [8*ID_BYTES-1:0]  TEST_ID     = 48'h0000554D4551,
   parameter logic [7:0]             BUS_CHAR    = 8'h26,
   parameter logic [7:0]             DEV_CHAR    = 8'h44
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic [1:0]        ev_kind,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic              ev_rnw,
   input  logic [7:0]        ev_data,
   output logic              rsp_valid,
   output logic              rsp_ack,
   output logic [7:0]        rsp_data
);

   localparam int ASSIGN_LAST = ID_BYTES + 2;
   localparam int OFF_W       = $clog2(ASSIGN_LAST + 1);

   if (ADDR_W != 7) begin : g_bad_addr_w
      $error("i3c_ccc_target: ADDR_W must be 7");
   end
   if (ID_BYTES < 1 || ID_BYTES > 8) begin : g_bad_id_bytes
      $error("i3c_ccc_target: ID_BYTES out of range");
   end
   if (STATIC_ADDR == ADDR_W'(BCAST_ADDR)) begin : g_bad_static
      $error("i3c_ccc_target: static address collides with broadcast");
   end

   ev_kind_e kind;
   assign kind = ev_kind_e'(ev_kind);

   logic [ADDR_W-1:0] dyn_addr;
   logic              selected;
   logic              in_bcast;
   logic              in_cmd;
   logic              assign_on;
   logic              test_mode;
   logic [7:0]        cmd;
   logic [OFF_W-1:0]  offset;

   logic              is_bcast;
   logic              hit;
   logic [7:0]        rd_byte;
   logic              rd_adv;

   i3c_ccc_addr_match #(.ADDR_W(ADDR_W)) i_match (
      .req_addr      (ev_addr),
      .static_addr   (STATIC_ADDR),
      .dyn_addr      (dyn_addr),
      .assign_active (assign_on),
      .is_bcast      (is_bcast),
      .hit           (hit)
   );

   i3c_ccc_rd_mux #(
      .ID_BYTES (ID_BYTES),
      .OFF_W    (OFF_W),
      .ID_VAL   (ID_VAL),
      .TEST_ID  (TEST_ID),
      .BUS_CHAR (BUS_CHAR),
      .DEV_CHAR (DEV_CHAR)
   ) i_rdmux (
      .in_cmd    (in_cmd),
      .cmd       (cmd),
      .offset    (offset),
      .test_mode (test_mode),
      .rd_byte   (rd_byte),
      .advance   (rd_adv)
   );

   logic unused_rnw;
   assign unused_rnw = ev_rnw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_ack   <= 1'b0;
         rsp_data  <= IDLE_BYTE;
         dyn_addr  <= '0;
         selected  <= 1'b0;
         in_bcast  <= 1'b0;
         in_cmd    <= 1'b0;
         assign_on <= 1'b0;
         test_mode <= 1'b0;
         cmd       <= '0;
         offset    <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (ev_valid) begin
            case (kind)
               EV_START: begin
                  rsp_valid <= 1'b1;
                  rsp_ack   <= hit;
                  rsp_data  <= IDLE_BYTE;
                  selected  <= hit;
                  in_bcast  <= is_bcast;
                  if (is_bcast && !assign_on) begin
                     in_cmd <= 1'b0;
                     cmd    <= '0;
                     offset <= '0;
                  end
               end
               EV_WRITE: begin
                  rsp_valid <= 1'b1;
                  rsp_ack   <= selected;
                  rsp_data  <= IDLE_BYTE;
                  if (selected) begin
                     if (in_bcast && !in_cmd) begin
                        cmd    <= ev_data;
                        in_cmd <= 1'b1;
                        offset <= '0;
                        case (ev_data)
                           CMD_ASSIGN:              assign_on <= 1'b1;
                           CMD_CLRADDR:             dyn_addr  <= '0;
                           CMD_ALLSTAT, CMD_ONESTAT: dyn_addr <= STATIC_ADDR;
                           default: ;
                        endcase
                     end else if (in_cmd) begin
                        case (cmd)
                           CMD_ASSIGN: begin
                              if (offset == OFF_W'(ASSIGN_LAST)) begin
                                 dyn_addr <= ev_data[ADDR_W-1:0];
                                 in_cmd   <= 1'b0;
                                 cmd      <= '0;
                                 offset   <= '0;
                              end
                           end
                           CMD_NEWADDR: begin
                              if (offset == '0) begin
                                 dyn_addr <= ev_data[ADDR_W-1:0];
                                 offset   <= OFF_W'(1);
                              end
                           end
                           CMD_TESTMODE: begin
                              if (offset == '0) begin
                                 test_mode <= |ev_data;
                                 offset    <= OFF_W'(1);
                              end
                           end
                           default: ;
                        endcase
                     end
                  end
               end
               EV_READ: begin
                  rsp_valid <= 1'b1;
                  rsp_ack   <= selected;
                  rsp_data  <= selected ? rd_byte : IDLE_BYTE;
                  if (selected && rd_adv) begin
                     offset <= offset + OFF_W'(1);
                  end
               end
               default: begin
                  selected  <= 1'b0;
                  in_bcast  <= 1'b0;
                  in_cmd    <= 1'b0;
                  assign_on <= 1'b0;
                  cmd       <= '0;
                  offset    <= '0;
               end
            endcase
         end
      end
   end

   assert_offset_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      offset <= OFF_W'(ASSIGN_LAST));

   assert_assigned_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && kind == EV_START && assign_on && dyn_addr != '0)
      |=> (rsp_valid && !rsp_ack));

   assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && kind == EV_STOP)
      |=> (!in_cmd && offset == '0 && !assign_on && !selected));

   assert_unselected_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && kind == EV_READ && !selected)
      |=> (rsp_valid && !rsp_ack && rsp_data == IDLE_BYTE));

   assert_one_response_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && kind != EV_STOP) |=> rsp_valid);

   assert_stop_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_valid || kind == EV_STOP) |=> !rsp_valid);

endmodule

// File: tb/test_i3c_ccc_target.sv
module test_i3c_ccc_target;

   localparam time        TCLK = 10ns;
   localparam logic [6:0] SA   = 7'h2A;
   localparam logic [47:0] IDV = 48'hA1B2C3D4E5F6;
   localparam logic [47:0] TID = 48'h0000554D4551;
   localparam logic [7:0] BCV  = 8'h26;
   localparam logic [7:0] DCV  = 8'h44;
   localparam logic [6:0] BC   = 7'h7E;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_valid = 1'b0;
   logic [1:0] ev_kind = 2'd0;
   logic [6:0] ev_addr = '0;
   logic       ev_rnw = 1'b0;
   logic [7:0] ev_data = '0;
   logic       rsp_valid;
   logic       rsp_ack;
   logic [7:0] rsp_data;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   typedef struct {
      logic       ack;
      logic [7:0] data;
      string      tag;
   } exp_t;

   exp_t sb[$];

   always #(TCLK/2) clk = ~clk;

   i3c_ccc_target #(
      .STATIC_ADDR (SA),
      .ID_VAL      (IDV),
      .TEST_ID     (TID),
      .BUS_CHAR    (BCV),
      .DEV_CHAR    (DCV)
   ) i_i3c_ccc_target (
      .clk, .rst_n, .ev_valid, .ev_kind, .ev_addr, .ev_rnw, .ev_data,
      .rsp_valid, .rsp_ack, .rsp_data
   );

   // Monitor: one queued expectation per response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         vectors++;
         if (sb.size() == 0) begin
            fails++;
            $display("FAIL R2: unexpected response ack=%0b data=%02h, expected none",
                     rsp_ack, rsp_data);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (rsp_ack !== e.ack || rsp_data !== e.data) begin
               fails++;
               $display("FAIL %s: ack=%0b data=%02h, expected ack=%0b data=%02h",
                        e.tag, rsp_ack, rsp_data, e.ack, e.data);
            end
         end
      end
   end

   task automatic push(input logic a, input logic [7:0] d, input string tag);
      exp_t e;
      e.ack = a; e.data = d; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic st(input logic [6:0] a, input logic rnw, input logic exp, input string tag);
      @(negedge clk);
      ev_valid = 1'b1; ev_kind = 2'd0; ev_addr = a; ev_rnw = rnw;
      push(exp, 8'hFF, tag);
   endtask

   task automatic wr(input logic [7:0] d, input logic exp, input string tag);
      @(negedge clk);
      ev_valid = 1'b1; ev_kind = 2'd1; ev_data = d;
      push(exp, 8'hFF, tag);
   endtask

   task automatic rd(input logic exp, input logic [7:0] d, input string tag);
      @(negedge clk);
      ev_valid = 1'b1; ev_kind = 2'd2;
      push(exp, d, tag);
   endtask

   task automatic sp();
      @(negedge clk);
      ev_valid = 1'b1; ev_kind = 2'd3;
   endtask

   task automatic idle();
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   // broadcast command with no payload, then STOP
   task automatic bcmd(input logic [7:0] c, input string tag);
      st(BC, 1'b0, 1'b1, tag);
      wr(c, 1'b1, tag);
      sp();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      vectors++;
      if (rsp_valid !== 1'b0 || rsp_data !== 8'hFF) begin
         fails++;
         $display("FAIL R1: valid=%0b data=%02h, expected valid=0 data=ff", rsp_valid, rsp_data);
      end
      rst_n = 1'b1;
      idle();

      // R2: static address match, other address, broadcast
      st(SA, 1'b0, 1'b1, "R1_static_ack");
      st(7'h2B, 1'b0, 1'b0, "R2_other_nack");
      st(BC, 1'b0, 1'b1, "R2_bcast_ack");
      sp();

      // R10: read with no command
      st(SA, 1'b1, 1'b1, "R10");
      rd(1'b1, 8'hFF, "R10_idle_read");
      sp();

      // R9: read-ID, bus and device characteristics commands
      st(BC, 1'b0, 1'b1, "R9");
      wr(8'h8D, 1'b1, "R9");
      st(SA, 1'b1, 1'b1, "R9");
      for (int i = 0; i < 6; i++) rd(1'b1, IDV[8*i +: 8], "R9_id");
      rd(1'b1, 8'hFF, "R9_past_id");
      sp();
      st(BC, 1'b0, 1'b1, "R9"); wr(8'h8E, 1'b1, "R9"); st(SA, 1'b1, 1'b1, "R9");
      rd(1'b1, BCV, "R9_buschar");
      sp();
      st(BC, 1'b0, 1'b1, "R9"); wr(8'h8F, 1'b1, "R9"); st(SA, 1'b1, 1'b1, "R9");
      rd(1'b1, DCV, "R9_devchar");
      sp();

      // R11: unknown command, unselected frame
      st(BC, 1'b0, 1'b1, "R11"); wr(8'h55, 1'b1, "R11"); st(SA, 1'b1, 1'b1, "R11");
      rd(1'b1, 8'hFF, "R11_unknown_read");
      sp();
      st(SA, 1'b0, 1'b1, "R11_addr_kept");
      sp();
      st(7'h2B, 1'b1, 1'b0, "R11");
      rd(1'b0, 8'hFF, "R11_unsel_read");
      wr(8'h12, 1'b0, "R11_unsel_write");
      sp();

      // R3/R4/R5: address assignment
      st(BC, 1'b0, 1'b1, "R3"); wr(8'h07, 1'b1, "R4");
      st(BC, 1'b1, 1'b1, "R3_unassigned_ack");
      for (int i = 0; i < 6; i++) rd(1'b1, IDV[8*i +: 8], "R4_id");
      rd(1'b1, BCV, "R4_buschar");
      rd(1'b1, DCV, "R4_devchar");
      rd(1'b1, 8'hFF, "R4_past_end");
      wr(8'h31, 1'b1, "R5");
      st(BC, 1'b1, 1'b0, "R5_assigned_nack");
      sp();
      st(7'h31, 1'b0, 1'b1, "R5_new_addr_ack");
      st(SA, 1'b0, 1'b0, "R2_static_ignored");
      sp();

      // R6: clear dynamic address
      bcmd(8'h06, "R6");
      st(SA, 1'b0, 1'b1, "R6_clr_static_ack");
      st(7'h31, 1'b0, 1'b0, "R6_clr_old_nack");
      sp();

      // R7: new address through directed frame
      st(BC, 1'b0, 1'b1, "R7"); wr(8'h88, 1'b1, "R7");
      st(SA, 1'b0, 1'b1, "R7"); wr(8'h40, 1'b1, "R7");
      sp();
      st(7'h40, 1'b0, 1'b1, "R7_new_ack");
      st(SA, 1'b0, 1'b0, "R7_static_nack");
      sp();

      // R6: copy static (all-targets form)
      bcmd(8'h29, "R6");
      st(SA, 1'b0, 1'b1, "R6_allstat_ack");
      st(7'h40, 1'b0, 1'b0, "R6_allstat_old_nack");
      sp();
      st(BC, 1'b0, 1'b1, "R7"); wr(8'h88, 1'b1, "R7");
      st(SA, 1'b0, 1'b1, "R7"); wr(8'h45, 1'b1, "R7");
      sp();
      bcmd(8'h87, "R6");
      st(SA, 1'b0, 1'b1, "R6_onestat_ack");
      st(7'h45, 1'b0, 1'b0, "R6_onestat_old_nack");
      sp();

      // R3: assignment with an address already held
      st(BC, 1'b0, 1'b1, "R3"); wr(8'h07, 1'b1, "R3");
      st(BC, 1'b1, 1'b0, "R3_has_addr_nack");
      sp();

      // R8: test mode
      st(BC, 1'b0, 1'b1, "R8"); wr(8'h0B, 1'b1, "R8"); wr(8'h01, 1'b1, "R8");
      sp();
      bcmd(8'h06, "R8");
      st(BC, 1'b0, 1'b1, "R8"); wr(8'h07, 1'b1, "R8");
      st(BC, 1'b1, 1'b1, "R8");
      for (int i = 0; i < 6; i++) rd(1'b1, TID[8*i +: 8], "R8_test_id");
      rd(1'b1, BCV, "R8_buschar");
      rd(1'b1, DCV, "R8_devchar");
      wr(8'h33, 1'b1, "R8");
      sp();
      st(BC, 1'b0, 1'b1, "R8"); wr(8'h8D, 1'b1, "R8"); st(7'h33, 1'b1, 1'b1, "R8");
      rd(1'b1, IDV[7:0], "R8_rdid_real");
      sp();
      st(BC, 1'b0, 1'b1, "R8"); wr(8'h0B, 1'b1, "R8"); wr(8'h00, 1'b1, "R8");
      sp();
      bcmd(8'h06, "R8");
      st(BC, 1'b0, 1'b1, "R8"); wr(8'h07, 1'b1, "R8");
      st(BC, 1'b1, 1'b1, "R8");
      rd(1'b1, IDV[7:0], "R8_exit_real_id");
      sp();

      idle();
      repeat (3) @(negedge clk);
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL R2: %0d responses missing, expected 0", sb.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R2: watchdog expired, got hang, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule